// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo serial audio stream carried on three wires (bit clock, word select, serial data) and turns it into one 18-bit left sample and one 18-bit right sample per frame. Two such three-wire ports arrive at the block, and a select input picks which one is decoded. All six lines are asynchronous to the system clock. They pass through a synchroniser, and every decision is taken on the system clock at the rising edges of the selected bit clock.

A static two-bit format input picks how the serial word sits inside each word-select half-period. In standard I2S framing the word starts one bit clock after the word-select change, and any number of bits is accepted: a short word is padded with zeros at the bottom and a long word loses its surplus low bits. In the three LSB-justified framings (16, 18 or 20 bits) the word ends at the word-select change, and only the placement of that change tells the widths apart. Each completed frame raises a one-cycle valid strobe. A companion flag marks frames in which either half-period carried fewer than the minimum number of bit clocks.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is low, and in the first cycle after it, `frame_vld_o` and `frame_short_o` are 0 and `left_o` and `right_o` are all zeros.
- R2: With `fmt_sel` = 2'b00 (I2S), word select low carries the left word and high the right word. The word's MSB is the bit sampled on the second bit-clock rise after a word-select change, and the word runs to and includes the bit sampled on the rise where the next change is first seen. An 18-bit word is delivered unchanged.
- R3: In I2S mode a word of fewer than 18 bits is placed at the top of the sample and the unused low bits are zero.
- R4: In I2S mode only the first 18 bits of a longer word are kept; the later bits are dropped.
- R5: With `fmt_sel` = 2'b10 (18-bit LSB-justified), the sample is the last 18 bits sampled before the word-select change.
- R6: With `fmt_sel` = 2'b11 (20-bit LSB-justified), the last two bits before the change are skipped and the 18 bits before them form the sample.
- R7: With `fmt_sel` = 2'b01 (16-bit LSB-justified), the last 16 bits before the change form sample bits 17:2, bits 1:0 are zero, and bits sampled after the change never enter that sample.
- R8: `frame_vld_o` is high for exactly one cycle per frame, three system clocks after the bit-clock rise at the pin on which word select is first seen low after a right half. `left_o` and `right_o` change only in that cycle and hold otherwise.
- R9: `frame_short_o` is high together with `frame_vld_o` when the left or right half-period of that frame had fewer than 16 bit-clock rises. A half-period of exactly 16 is not short.
- R10: `src_sel` = 0 decodes port A and `src_sel` = 1 decodes port B; traffic on the other port produces no output.
- R11: A change of `src_sel` drops any partly received frame: no valid strobe follows until a full left and right half has arrived on the new port, starting from a word-select falling edge.
- R12: After reset, no frame is delivered until a left half-period that began at an observed word-select falling edge has been completed by a right half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 1 | Source port select: 0 = port A, 1 = port B |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 LSB-justified 16, 10 LSB-justified 18, 11 LSB-justified 20 |
| a_bck | input | 1 | Port A bit clock |
| a_ws | input | 1 | Port A word select |
| a_sd | input | 1 | Port A serial data |
| b_bck | input | 1 | Port B bit clock |
| b_ws | input | 1 | Port B word select |
| b_sd | input | 1 | Port B serial data |
| left_o | output | 18 | Last delivered left sample |
| right_o | output | 18 | Last delivered right sample |
| frame_vld_o | output | 1 | One-cycle strobe per completed frame |
| frame_short_o | output | 1 | Frame had a half-period below 16 bit clocks (valid with strobe) |

## Verification
The short-frame flag and the frame strobe must fall in the same cycle. The bench provokes this with frames whose half-periods carry 10, 12, 14, 15 and 16 bit clocks, so the flag is judged on the exact cycle of the strobe and must stay clear at the boundary of 16. A source switch can also land in the middle of a frame whose completion is near. The bench switches ports in the middle of a left half and again just after a right half, one bit clock before the edge that would complete the frame. Its behavioural model predicts that no strobe appears for the dropped frame, and every cycle is compared against that prediction.

// File: rtl/aud_rx_pkg.sv
// Package: shared framing codes for the serial audio receiver.
// Assumes the format select is static while frames are being decoded.
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_LJ16 = 2'b01,
        FMT_LJ18 = 2'b10,
        FMT_LJ20 = 2'b11
    } fmt_e;

endpackage

// File: rtl/aud_rx_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous lines.
// Assumes each line is slow compared with clk, so that the bits of the
// bundle do not need to stay coherent with one another.
module aud_rx_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: captures the asynchronous lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                // Further flops: let metastability resolve.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/aud_rx_front.sv
// Module: front end. Synchronises both ports, selects one, turns rising
// edges of the selected bit clock into a one-cycle strobe, and raises a
// flush request when the source select changes.
// Assumes the bit clock is at least two system clocks high and two low.
module aud_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic a_bck,
    input  logic a_ws,
    input  logic a_sd,
    input  logic b_bck,
    input  logic b_ws,
    input  logic b_sd,
    output logic stb_o,
    output logic ws_o,
    output logic sd_o,
    output logic flush_o
);

    localparam int LINES = 6;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] syn;
    logic             sel_q;
    logic             bck_m;
    logic             bck_prev;

    assign raw = {b_bck, b_ws, b_sd, a_bck, a_ws, a_sd};

    aud_rx_sync #(
        .W      (LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    // Remember the select last seen so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= src_sel;
    end

    assign flush_o = (src_sel != sel_q);

    // Route the synchronised lines of the active port.
    always_comb begin
        if (sel_q) {bck_m, ws_o, sd_o} = syn[5:3];
        else       {bck_m, ws_o, sd_o} = syn[2:0];
    end

    // Delay the selected bit clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bck_prev <= 1'b0;
        else        bck_prev <= bck_m;
    end

    assign stb_o = bck_m & ~bck_prev;

    // Two rising edges can never be reported in consecutive cycles.
    assert_stb_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o)
        else $error("bit-clock strobe repeated in consecutive cycles");

endmodule

// File: rtl/aud_rx_word.sv
// Module: word assembler. Collects the bits of one word-select half-period
// for both framings at once: an MSB-first accumulator for I2S and a
// shift window for LSB-justified data. On the strobe where word select
// changes it offers the completed word for the chosen format.
// Assumes clear_i is raised on the strobe that starts a new half-period.
module aud_rx_word
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int PAD_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                stb_i,
    input  logic                sd_i,
    input  logic                clear_i,
    input  fmt_e                fmt_i,
    output logic [SAMPLE_W-1:0] word_o
);

    localparam int WIN_W  = SAMPLE_W + PAD_W;
    localparam int IDX_W  = $clog2(SAMPLE_W + 1);
    localparam int NARROW = SAMPLE_W - PAD_W;
    localparam logic [IDX_W-1:0]    IDX_FULL = IDX_W'(SAMPLE_W);
    localparam logic [SAMPLE_W-1:0] TOP_BIT  = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] acc;
    logic [IDX_W-1:0]    idx;
    logic [WIN_W-1:0]    win;
    logic [SAMPLE_W-1:0] cur_bit;
    logic [SAMPLE_W-1:0] i2s_word;

    // One-hot position of the current bit within the I2S word.
    assign cur_bit = (sd_i && (idx < IDX_FULL)) ? (TOP_BIT >> idx) : '0;

    // I2S accumulator: place bits MSB first, ignore bits past the width.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            acc <= '0;
            idx <= '0;
        end else if (stb_i) begin
            if (clear_i) begin
                acc <= '0;
                idx <= '0;
            end else begin
                acc <= acc | cur_bit;
                if (idx < IDX_FULL) idx <= idx + 1'b1;
            end
        end
    end

    // LSB-justified window: keep the most recent WIN_W bits of the half.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            win <= '0;
        end else if (stb_i) begin
            if (clear_i) win <= {{(WIN_W-1){1'b0}}, sd_i};
            else         win <= {win[WIN_W-2:0], sd_i};
        end
    end

    // The I2S word closes with the bit on the changing strobe.
    assign i2s_word = acc | cur_bit;

    // Pick the completed word for the current format.
    always_comb begin
        unique case (fmt_i)
            FMT_I2S:  word_o = i2s_word;
            FMT_LJ16: word_o = {win[NARROW-1:0], {PAD_W{1'b0}}};
            FMT_LJ18: word_o = win[SAMPLE_W-1:0];
            default:  word_o = win[WIN_W-1:PAD_W];
        endcase
    end

    // The I2S bit index never runs past the sample width.
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i && !clear_i && (idx == IDX_FULL) |=> (idx == IDX_FULL))
        else $error("I2S bit index left its saturated value");

endmodule

// File: rtl/aud_rx_framer.sv
// Module: framer. Tracks word-select half-periods, counts bit clocks in
// each, pairs a left word with the following right word and delivers
// them with a one-cycle strobe. A frame is delivered only after the
// framer has been armed by a word-select falling edge.
// Assumes stb_i marks a bit-clock rise and ws_i/sd_i are stable there.
module aud_rx_framer #(
    parameter int SAMPLE_W  = 18,
    parameter int MIN_BCK   = 16,
    parameter int MAX_SLOTS = 255
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                stb_i,
    input  logic                ws_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic                clear_o,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                short_o
);

    localparam int CNT_W = $clog2(MAX_SLOTS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SLOTS);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_BCK);

    logic                fresh;
    logic                prev_ws;
    logic                armed;
    logic                have_left;
    logic                left_short;
    logic [SAMPLE_W-1:0] left_buf;
    logic [CNT_W-1:0]    cnt;
    logic                ws_chg;
    logic                half_short;

    assign ws_chg     = stb_i && !fresh && (ws_i != prev_ws);
    assign clear_o    = stb_i && (fresh || (ws_i != prev_ws));
    assign half_short = (cnt < CNT_MIN);

    // Half-period tracking: last word select seen and bit-clock count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            fresh   <= 1'b1;
            prev_ws <= 1'b0;
            cnt     <= '0;
        end else if (stb_i) begin
            fresh   <= 1'b0;
            prev_ws <= ws_i;
            if (clear_o)             cnt <= CNT_W'(1);
            else if (cnt < CNT_MAX)  cnt <= cnt + 1'b1;
        end
    end

    // Frame pairing: arm on a falling edge, hold the left word, pair it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            armed      <= 1'b0;
            have_left  <= 1'b0;
            left_short <= 1'b0;
            left_buf   <= '0;
        end else if (ws_chg) begin
            if (!ws_i) begin
                armed     <= 1'b1;
                have_left <= 1'b0;
            end else if (armed) begin
                left_buf   <= word_i;
                left_short <= half_short;
                have_left  <= 1'b1;
            end
        end
    end

    // Output stage: strobe and short flag for one cycle, samples held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            short_o <= 1'b0;
            left_o  <= '0;
            right_o <= '0;
        end else begin
            valid_o <= 1'b0;
            short_o <= 1'b0;
            if (!flush_i && ws_chg && !ws_i && armed && have_left) begin
                valid_o <= 1'b1;
                short_o <= left_short | half_short;
                left_o  <= left_buf;
                right_o <= word_i;
            end
        end
    end

    assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o)
        else $error("frame strobe wider than one cycle");

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)))
        else $error("samples changed without a frame strobe");

    assert_short_with_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
        short_o |-> valid_o)
        else $error("short flag raised outside a frame strobe");

    assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !valid_o)
        else $error("frame delivered across a source change");

    assert_left_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(have_left))
        else $error("frame delivered without a completed left half");

endmodule

// File: rtl/audio_serial_rx.sv
// Module: top of the multi-format serial audio receiver. Connects the
// front end, the word assembler and the framer.
// Assumes fmt_sel is static while frames arrive and that src_sel is
// changed while both bit clocks are low.
module audio_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W    = 18,
    parameter int PAD_W       = 2,
    parameter int MIN_BCK     = 16,
    parameter int MAX_SLOTS   = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_sel,
    input  logic [1:0]          fmt_sel,
    input  logic                a_bck,
    input  logic                a_ws,
    input  logic                a_sd,
    input  logic                b_bck,
    input  logic                b_ws,
    input  logic                b_sd,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                frame_vld_o,
    output logic                frame_short_o
);

    logic                stb;
    logic                ws;
    logic                sd;
    logic                flush;
    logic                clear;
    logic [SAMPLE_W-1:0] word;
    fmt_e                fmt;

    assign fmt = fmt_e'(fmt_sel);

    aud_rx_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) front_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .a_bck   (a_bck),
        .a_ws    (a_ws),
        .a_sd    (a_sd),
        .b_bck   (b_bck),
        .b_ws    (b_ws),
        .b_sd    (b_sd),
        .stb_o   (stb),
        .ws_o    (ws),
        .sd_o    (sd),
        .flush_o (flush)
    );

    aud_rx_word #(
        .SAMPLE_W (SAMPLE_W),
        .PAD_W    (PAD_W)
    ) word_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .stb_i   (stb),
        .sd_i    (sd),
        .clear_i (clear),
        .fmt_i   (fmt),
        .word_o  (word)
    );

    aud_rx_framer #(
        .SAMPLE_W  (SAMPLE_W),
        .MIN_BCK   (MIN_BCK),
        .MAX_SLOTS (MAX_SLOTS)
    ) framer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .stb_i   (stb),
        .ws_i    (ws),
        .word_i  (word),
        .clear_o (clear),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (frame_vld_o),
        .short_o (frame_short_o)
    );

    // Reset state of the outputs.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!frame_vld_o && !frame_short_o))
        else $error("strobe or flag active after a reset cycle");

endmodule

// File: tb/audio_serial_rx_tb_top.sv
// Bench: drives bit-level frames on both ports and compares the outputs
// every clock against a behavioural model built on bit queues.
module audio_serial_rx_tb_top;

    localparam int SW  = 18;
    localparam int MIN = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_sel = 1'b0;
    logic [1:0]    fmt_sel = 2'b00;
    logic          a_bck = 0, a_ws = 0, a_sd = 0;
    logic          b_bck = 0, b_ws = 0, b_sd = 0;
    logic [SW-1:0] left_o, right_o;
    logic          frame_vld_o, frame_short_o;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string cur_tag = "R8";

    // Model state.
    bit            m_sel = 0;
    bit            m_fresh = 1;
    bit            m_prev = 0;
    bit            m_armed = 0;
    bit            m_have_left = 0;
    bit            m_lshort = 0;
    logic [SW-1:0] m_lbuf = '0;
    bit            hq[$];

    int            eq_cyc[$];
    logic [SW-1:0] eq_l[$];
    logic [SW-1:0] eq_r[$];
    bit            eq_s[$];
    string         eq_tag[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    audio_serial_rx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_sel       (src_sel),
        .fmt_sel       (fmt_sel),
        .a_bck         (a_bck),
        .a_ws          (a_ws),
        .a_sd          (a_sd),
        .b_bck         (b_bck),
        .b_ws          (b_ws),
        .b_sd          (b_sd),
        .left_o        (left_o),
        .right_o       (right_o),
        .frame_vld_o   (frame_vld_o),
        .frame_short_o (frame_short_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Bit k counted back from the end of the half (k = 0 is the last bit).
    function automatic bit from_end(int k);
        return (k < hq.size()) ? hq[hq.size()-1-k] : 1'b0;
    endfunction

    // Expected word of the half held in hq, closed by bit b.
    function automatic logic [SW-1:0] model_word(bit b);
        logic [SW-1:0] w = '0;
        bit bits[$];
        case (fmt_sel)
            2'b00: begin
                for (int i = 1; i < hq.size(); i++) bits.push_back(hq[i]);
                bits.push_back(b);
                for (int i = 0; i < bits.size() && i < SW; i++) w[SW-1-i] = bits[i];
            end
            2'b10: for (int i = 0; i < SW; i++) w[i] = from_end(i);
            2'b11: for (int i = 0; i < SW; i++) w[i] = from_end(i + 2);
            default: for (int i = 0; i < SW - 2; i++) w[i+2] = from_end(i);
        endcase
        return w;
    endfunction

    // Model of one bit-clock rise on the selected port.
    task automatic model_rise(input bit ws, input bit sd);
        logic [SW-1:0] w;
        bit sh;
        if (m_fresh) begin
            m_fresh = 0;
            m_prev  = ws;
            hq.delete();
            hq.push_back(sd);
        end else if (ws != m_prev) begin
            w  = model_word(sd);
            sh = (hq.size() < MIN);
            m_prev = ws;
            if (!ws) begin
                if (m_armed && m_have_left) begin
                    eq_cyc.push_back(cyc + LAT);
                    eq_l.push_back(m_lbuf);
                    eq_r.push_back(w);
                    eq_s.push_back(m_lshort | sh);
                    eq_tag.push_back(cur_tag);
                end
                m_armed = 1;
                m_have_left = 0;
            end else if (m_armed) begin
                m_lbuf = w;
                m_lshort = sh;
                m_have_left = 1;
            end
            hq.delete();
            hq.push_back(sd);
        end else begin
            hq.push_back(sd);
        end
    endtask

    // One bit slot: set lines with bit clock low, then raise it.
    task automatic slot(input bit p, input bit ws, input bit sd);
        if (p) begin b_ws = ws; b_sd = sd; end
        else   begin a_ws = ws; a_sd = sd; end
        repeat (4) @(negedge clk);
        if (p) b_bck = 1'b1; else a_bck = 1'b1;
        if (p == m_sel) model_rise(ws, sd);
        repeat (4) @(negedge clk);
        if (p) b_bck = 1'b0; else a_bck = 1'b0;
    endtask

    task automatic half(input bit p, input bit ws, input int n);
        for (int i = 0; i < n; i++) slot(p, ws, 1'($urandom_range(0, 1)));
    endtask

    task automatic frame(input bit p, input int nl, input int nr);
        half(p, 1'b0, nl);
        half(p, 1'b1, nr);
    endtask

    // Close the current frame with the first slot of the next left half.
    task automatic close(input bit p);
        slot(p, 1'b0, 1'($urandom_range(0, 1)));
        repeat (8) @(negedge clk);
    endtask

    task automatic switch_src(input bit s);
        src_sel = s;
        m_sel = s;
        m_fresh = 1;
        m_armed = 0;
        m_have_left = 0;
        hq.delete();
        repeat (3) @(negedge clk);
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            if (eq_cyc.size() > 0 && eq_cyc[0] == cyc) begin
                check(eq_tag[0], "valid", SW'(frame_vld_o), SW'(1));
                check(eq_tag[0], "left",  left_o,  eq_l[0]);
                check(eq_tag[0], "right", right_o, eq_r[0]);
                check(eq_s[0] ? "R9" : eq_tag[0], "short",
                      SW'(frame_short_o), SW'(eq_s[0]));
                void'(eq_cyc.pop_front());
                void'(eq_l.pop_front());
                void'(eq_r.pop_front());
                void'(eq_s.pop_front());
                void'(eq_tag.pop_front());
            end else begin
                check(cur_tag, "valid", SW'(frame_vld_o), SW'(0));
                check("R9", "short", SW'(frame_short_o), SW'(0));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state.
        check("R1", "valid", SW'(frame_vld_o), SW'(0));
        check("R1", "short", SW'(frame_short_o), SW'(0));
        check("R1", "left",  left_o,  '0);
        check("R1", "right", right_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "left after release", left_o, '0);
        chk_on = 1;

        // R12: stream begins mid right half; first frame needs a full left.
        cur_tag = "R12";
        half(0, 1'b1, 20);
        cur_tag = "R2";
        frame(0, 18, 18);
        frame(0, 18, 18);
        // R3: short words padded at the bottom.
        cur_tag = "R3";
        frame(0, 16, 17);
        frame(0, 17, 16);
        // R4: long words truncated.
        cur_tag = "R4";
        frame(0, 24, 32);
        frame(0, 19, 21);
        // R9: short half-periods and the 16 boundary.
        cur_tag = "R9";
        frame(0, 10, 12);
        frame(0, 15, 20);
        frame(0, 20, 15);
        frame(0, 16, 16);
        close(0);

        // R5: 18-bit LSB-justified.
        fmt_sel = 2'b10;
        cur_tag = "R5";
        frame(0, 18, 18);
        frame(0, 20, 24);
        // R6: 20-bit LSB-justified.
        fmt_sel = 2'b11;
        cur_tag = "R6";
        frame(0, 20, 20);
        frame(0, 22, 25);
        // R7: 16-bit LSB-justified, including a short half.
        fmt_sel = 2'b01;
        cur_tag = "R7";
        frame(0, 16, 16);
        frame(0, 20, 18);
        frame(0, 14, 20);
        close(0);

        // R11: switch in the middle of a left half.
        fmt_sel = 2'b00;
        cur_tag = "R11";
        half(0, 1'b0, 9);
        switch_src(1'b1);
        half(1, 1'b1, 18);
        // R10: traffic on the idle port is ignored.
        cur_tag = "R10";
        frame(0, 18, 18);
        close(0);
        frame(1, 18, 18);
        frame(1, 20, 17);
        close(1);
        // R11: switch just after a right half, before the closing edge.
        cur_tag = "R11";
        frame(1, 18, 18);
        switch_src(1'b0);
        slot(1, 1'b0, 1'b1);
        half(0, 1'b1, 18);
        frame(0, 18, 18);
        close(0);

        repeat (10) @(negedge clk);
        if (eq_cyc.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R8 pending frames actual=%0d expected=0", eq_cyc.size());
        end
        finish_run();
    end

endmodule